// File: doc/BRIEF.md
# Key-Sequence Register Unlock Controller

This block stands in front of a small protected control register and decides, write by write, whether software may touch it. Software must write two fixed 32-bit key words, back to back, into a key register before the control register accepts changes. Two further key registers use the same two-word sequence. One opens a fast program/erase privilege and the other opens access to a boot area. Both work only while the main control register is unlocked.

The sequence is strict. A wrong word, the words in the wrong order, a key written to a channel that is already open, or any unrelated write that lands between the two words counts as a sequence error. A sequence error latches a hard lockout. In that state all three privileges stay shut and every bus access is answered with a bus error until the next reset. Software closes all three privileges again by writing the LOCK bit of the control register. The block sits on a simple single-cycle register bus with separate read and write strobes. Errors are reported as a bus-error pulse in the same cycle as the strobe that caused them.

Top module: `key_unlock_ctrl`

## Requirements
- R1: After reset, `ctrl_locked`, `fast_locked` and `boot_locked` are 1, `hard_locked` is 0 and `ctrl_field` is 0.
- R2: A write of 0x45670123 to the main key address (1), followed by the next write being 0xCDEF89AB to the same address, clears `ctrl_locked` in the cycle after the second write.
- R3: A write to the control address (0) while `ctrl_locked` is 1 leaves `ctrl_field` unchanged and raises `bus_err` in the same cycle, without hard lockout. While unlocked, a write with the LOCK bit (bit 7) at 0 loads `wdata[3:0]` into `ctrl_field`.
- R4: A wrong key word at either step of a sequence raises `bus_err` in that cycle and sets `hard_locked` in the next cycle.
- R5: Any write to another address while a channel waits for its second word is a sequence error, handled as in R4. Reads in between do not break the sequence.
- R6: While `hard_locked` is 1, every read or write raises `bus_err` and reads return 0. All three lock flags stay at 1 and nothing changes until reset.
- R7: A write to the control address with bit 7 set, while unlocked, sets all three lock flags to 1 in the next cycle and leaves `ctrl_field` unchanged.
- R8: The same two-word sequence at the fast key address (2) clears `fast_locked`, and at the boot key address (3) clears `boot_locked`, provided the main channel is open. A write to either address while `ctrl_locked` is 1 raises `bus_err`, is ignored and does not hard-lock.
- R9: Writing any word to a key address whose channel is already open is a sequence error, handled as in R4.
- R10: Reads of the key addresses, and of unmapped addresses, return 0 without `bus_err` outside hard lockout. Writes to unmapped addresses are ignored.
- R11: A read of the control address returns `ctrl_field` in bits 3:0 and `ctrl_locked` in bit 7, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rd_en` |
| bus_err | output | 1 | Bus-error pulse with the offending strobe |
| ctrl_locked | output | 1 | Control register locked |
| fast_locked | output | 1 | Fast program/erase privilege locked |
| boot_locked | output | 1 | Boot area locked |
| hard_locked | output | 1 | Sticky lockout after a sequence error |
| ctrl_field | output | FIELD_W | Protected control field |

## Verification
The bench builds the block with its defaults: a 4-bit address, a 4-bit control field and the LOCK bit at position 7. The 4-bit address leaves twelve unmapped words. The bench aims at address 4 for the ignored-write and zero-read cases, and for interrupting a pending sequence from outside the mapped set. With the field below the LOCK bit, random control writes can load the field and relock in the same data stream. Periodic forced unlock pairs let random traffic reach the fast and boot channels instead of dying in lockout.

// File: rtl/key_unlock_ctrl.sv
module key_unlock_ctrl #(
  parameter int ADDR_W = 4,
  parameter int FIELD_W = 4,
  parameter int LOCK_BIT = 7,
  parameter logic [31:0] KEY_A = 32'h4567_0123,
  parameter logic [31:0] KEY_B = 32'hCDEF_89AB,
  parameter logic [ADDR_W-1:0] A_CTRL = 'h0,
  parameter logic [ADDR_W-1:0] A_MAIN = 'h1,
  parameter logic [ADDR_W-1:0] A_FAST = 'h2,
  parameter logic [ADDR_W-1:0] A_BOOT = 'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              bus_err,
  output logic              ctrl_locked,
  output logic              fast_locked,
  output logic              boot_locked,
  output logic              hard_locked,
  output logic [FIELD_W-1:0] ctrl_field
);
  localparam int NCH = 3;
  localparam logic [1:0] S_IDLE = 2'd0, S_HALF = 2'd1, S_OPEN = 2'd2;

  logic [1:0] st [NCH];
  logic [NCH-1:0] hit, bad, pend;
  logic hard, main_open, ctrl_hit, seq_err, lock_err;
  logic [FIELD_W-1:0] field;

  function automatic logic [ADDR_W-1:0] key_addr(input int i);
    case (i)
      0: key_addr = A_MAIN;
      1: key_addr = A_FAST;
      default: key_addr = A_BOOT;
    endcase
  endfunction

  assign main_open = (st[0] == S_OPEN);
  assign ctrl_hit  = wr_en && (addr == A_CTRL);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit[i]  = wr_en && (addr == key_addr(i));
      pend[i] = (st[i] == S_HALF) && !hit[i];
      bad[i]  = hit[i] && (i == 0 || main_open) &&
                ((st[i] == S_OPEN) ||
                 (st[i] == S_IDLE && wdata != KEY_A) ||
                 (st[i] == S_HALF && wdata != KEY_B));
    end
  end

  assign seq_err  = wr_en && !hard && ((|pend) || (|bad));
  assign lock_err = wr_en && !hard && !seq_err && !main_open &&
                    (ctrl_hit || hit[1] || hit[2]);
  assign bus_err  = (hard && (wr_en || rd_en)) || seq_err || lock_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard  <= 1'b0;
      field <= '0;
      for (int i = 0; i < NCH; i++) st[i] <= S_IDLE;
    end else if (seq_err) begin
      hard <= 1'b1;
      for (int i = 0; i < NCH; i++) st[i] <= S_IDLE;
    end else if (wr_en && !hard && !lock_err) begin
      if (ctrl_hit) begin
        if (wdata[LOCK_BIT]) for (int i = 0; i < NCH; i++) st[i] <= S_IDLE;
        else field <= wdata[FIELD_W-1:0];
      end
      for (int i = 0; i < NCH; i++)
        if (hit[i]) st[i] <= (st[i] == S_IDLE) ? S_HALF : S_OPEN;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && !hard && addr == A_CTRL) begin
      rdata[FIELD_W-1:0] = field;
      rdata[LOCK_BIT]    = !main_open;
    end
  end

  assign ctrl_locked = !main_open;
  assign fast_locked = (st[1] != S_OPEN);
  assign boot_locked = (st[2] != S_OPEN);
  assign hard_locked = hard;
  assign ctrl_field  = field;

  // R6
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_locked |=> hard_locked);
  // R4
  hard_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_locked) |-> $past(bus_err && wr_en));
  // R8
  sub_needs_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_locked || !boot_locked) |-> !ctrl_locked);
  // R3
  field_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_locked |=> $stable(ctrl_field));
  // R6
  err_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (wr_en || rd_en));
  // R2
  unlock_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_locked) |-> $past(wr_en && addr == A_MAIN && wdata == KEY_B));
endmodule

// File: tb/tb_key_unlock_ctrl.sv
module tb_key_unlock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic bus_err, ctrl_locked, fast_locked, boot_locked, hard_locked;
  logic [3:0] ctrl_field;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_st[3], n_st[3];
  bit m_hard, n_hard;
  logic [3:0] m_field, n_field;

  key_unlock_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .bus_err(bus_err),
    .ctrl_locked(ctrl_locked), .fast_locked(fast_locked), .boot_locked(boot_locked),
    .hard_locked(hard_locked), .ctrl_field(ctrl_field));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk(ctrl_locked == (m_st[0] != 2), tag, "ctrl_locked", 32'(ctrl_locked), 32'(m_st[0] != 2));
    chk(fast_locked == (m_st[1] != 2), tag, "fast_locked", 32'(fast_locked), 32'(m_st[1] != 2));
    chk(boot_locked == (m_st[2] != 2), tag, "boot_locked", 32'(boot_locked), 32'(m_st[2] != 2));
    chk(hard_locked == m_hard, tag, "hard_locked", 32'(hard_locked), 32'(m_hard));
    chk(ctrl_field == m_field, tag, "ctrl_field", 32'(ctrl_field), 32'(m_field));
  endtask

  task automatic model_eval(input bit w, input bit r, input logic [3:0] a,
                            input logic [31:0] d, output bit err, output logic [31:0] rd);
    int k;
    bit intr, mopen, seq;
    n_st = m_st; n_hard = m_hard; n_field = m_field;
    err = 0; rd = '0; seq = 0;
    mopen = (m_st[0] == 2);
    k = (a == 1) ? 0 : (a == 2) ? 1 : (a == 3) ? 2 : -1;
    if (m_hard) err = w | r;
    else if (r) begin
      if (a == 0) rd = {24'd0, !mopen, 3'd0, m_field};
    end else if (w) begin
      intr = 0;
      for (int i = 0; i < 3; i++) if (m_st[i] == 1 && i != k) intr = 1;
      if (intr) seq = 1;
      else if (k >= 0) begin
        if (k > 0 && !mopen) err = 1;
        else if (m_st[k] == 2 || (m_st[k] == 0 && d != K1) || (m_st[k] == 1 && d != K2)) seq = 1;
        else n_st[k] = m_st[k] + 1;
      end else if (a == 0) begin
        if (!mopen) err = 1;
        else if (d[7]) n_st = '{0, 0, 0};
        else n_field = d[3:0];
      end
      if (seq) begin err = 1; n_hard = 1; n_st = '{0, 0, 0}; end
    end
  endtask

  task automatic op(input bit w, input bit r, input logic [3:0] a,
                    input logic [31:0] d, input string tag);
    bit e_err;
    logic [31:0] e_rd;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    model_eval(w, r, a, d, e_err, e_rd);
    chk(bus_err == e_err, tag, "bus_err", 32'(bus_err), 32'(e_err));
    if (r) chk(rdata == e_rd, tag, "rdata", rdata, e_rd);
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0;
    m_st = n_st; m_hard = n_hard; m_field = n_field;
    chk_flags(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0;
    m_st = '{0, 0, 0}; m_hard = 0; m_field = '0;
    repeat (2) @(negedge clk);
    chk_flags("R1");
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    op(0, 1, 4'd1, 0, "R10");
    op(0, 1, 4'd4, 0, "R10");
    op(1, 0, 4'd4, 32'h5, "R10");
    op(1, 0, 4'd0, 32'h3, "R3");
    op(1, 0, 4'd1, K1, "R2");
    op(0, 1, 4'd0, 0, "R5");
    op(1, 0, 4'd1, K2, "R2");
    op(1, 0, 4'd0, 32'h5, "R3");
    op(0, 1, 4'd0, 0, "R11");
    op(1, 0, 4'd2, K1, "R8");
    op(0, 1, 4'd2, 0, "R10");
    op(1, 0, 4'd2, K2, "R8");
    op(1, 0, 4'd3, K1, "R8");
    op(1, 0, 4'd3, K2, "R8");
    op(1, 0, 4'd0, 32'h80, "R7");
    op(0, 1, 4'd0, 0, "R11");
    op(1, 0, 4'd2, K1, "R8");
    op(1, 0, 4'd1, K1, "R4");
    op(1, 0, 4'd1, K1, "R4");
    op(0, 1, 4'd0, 0, "R6");
    op(1, 0, 4'd1, K1, "R6");
    op(1, 0, 4'd1, K2, "R6");
    do_reset();
    op(1, 0, 4'd1, K2, "R4");
    do_reset();
    op(1, 0, 4'd1, K1, "R5");
    op(1, 0, 4'd4, 32'h0, "R5");
    do_reset();
    op(1, 0, 4'd1, K1, "R9");
    op(1, 0, 4'd1, K2, "R9");
    op(1, 0, 4'd1, K1, "R9");
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      int sel;
      if (m_hard && $urandom_range(0, 7) == 0) do_reset();
      if (!m_hard && $urandom_range(0, 5) == 0) begin
        logic [3:0] ka;
        ka = (m_st[0] == 2) ? 4'($urandom_range(1, 3)) : 4'd1;
        op(1, 0, ka, K1, "R2");
        op(1, 0, ka, K2, "R8");
      end
      sel = $urandom_range(0, 3);
      d = (sel == 0) ? K1 : (sel == 1) ? K2 : (sel == 2) ? $urandom : ($urandom & 32'h8F);
      if ($urandom_range(0, 2) == 0) op(0, 1, 4'($urandom_range(0, 4)), 0, m_hard ? "R6" : "R11");
      else op(1, 0, 4'($urandom_range(0, 4)), d, m_hard ? "R6" : "R5");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule